// File: doc/BRIEF.md
# AXI4 Burst DMA Master

This block is a memory-side AXI4 master with two engines that work side by side: one writes, one reads. Each engine accepts a command over a valid/ready handshake. A command carries a byte start address, which must be 8-byte aligned, and a beat count. The count is the number of 64-bit beats minus one, and it becomes the AXI burst length without change. Each command becomes exactly one INCR burst of 8-byte beats on transaction ID 0. The caller must make sure that no burst crosses a 4 KB address boundary; the block does not split bursts.

The write engine forwards 64-bit words from an input valid/ready stream onto the write data channel, with all byte strobes set. The read engine forwards returned read beats onto an output valid/ready stream, and downstream backpressure stalls the read data channel directly.

An engine's command-ready output also serves as its completion signal. It drops on the cycle after a command is accepted. It rises again only after the whole burst is finished: the write response for a write, or the final read beat for a read. An issuer can therefore wait for ready to return and know that the transfer is done. A response other than OKAY sets a sticky error flag for that engine. Only reset clears the flag, and the engine still returns to ready.

Top module: `axi_burst_dma`

## Requirements
- R1: While reset is active and on the first cycle after it, both command-ready outputs are 1; the address-valid, write-valid, response-ready and read-ready outputs are 0; and both error flags are 0.
- R2: Once a write command is accepted, on the next cycle the write command ready is 0 and the address channel presents: valid 1, address equal to the command address, length equal to the command count, size code 3 (8 bytes), burst type 2'b01 (INCR) and ID 0.
- R3: While the write address is valid and not accepted, valid stays at 1 and the address and length do not change.
- R4: In the data phase, write valid equals the input stream valid and input ready equals the write channel ready. Write data equals the input word and the strobes are 8'hFF. Before the address is accepted, input ready and write valid are both 0.
- R5: The burst carries exactly count+1 beats. Write-last is 1 only on the beat whose zero-based index equals the count, and no write valid follows it.
- R6: Response ready is 1 only after the last data beat. Write command ready stays 0 from acceptance until the response handshake and is 1 on the cycle after it.
- R7: Once a read command is accepted, on the next cycle the read address channel presents: valid 1, the command address, the count as length, size code 3, INCR (2'b01) and ID 0. These values are held until accepted.
- R8: In the read data phase, the output stream valid equals read valid, read ready equals the output stream ready, and the output word equals the read data. Before the address is accepted, both are 0.
- R9: Read command ready stays 0 from acceptance until the read beat flagged last is handshaken and is 1 on the cycle after it.
- R10: A write response or any read beat whose response is not 2'b00 (OKAY) sets that engine's error flag. The flag stays set through later good bursts, is cleared only by reset, and the engine still returns to ready.
- R11: The write and read engines run at the same time without disturbing each other's handshakes or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd_addr | input | 32 | Write burst start byte address (8-byte aligned) |
| wr_cmd_len | input | 8 | Write beats minus one |
| wr_cmd_valid | input | 1 | Write command valid |
| wr_cmd_ready | output | 1 | Write command ready / write burst complete |
| wr_in_data | input | 64 | Write stream word |
| wr_in_valid | input | 1 | Write stream valid |
| wr_in_ready | output | 1 | Write stream ready |
| rd_cmd_addr | input | 32 | Read burst start byte address (8-byte aligned) |
| rd_cmd_len | input | 8 | Read beats minus one |
| rd_cmd_valid | input | 1 | Read command valid |
| rd_cmd_ready | output | 1 | Read command ready / read burst complete |
| rd_out_data | output | 64 | Read stream word |
| rd_out_valid | output | 1 | Read stream valid |
| rd_out_ready | input | 1 | Read stream ready |
| wr_err | output | 1 | Sticky write response error |
| rd_err | output | 1 | Sticky read response error |
| m_awid | output | 1 | Write address ID |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Write burst length |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_arid | output | 1 | Read address ID |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Read burst length |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 64 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Every burst length from 1 to 16 beats, plus the maximum of 256, is run on both engines in two modes. The first mode has the memory side and the stream side always ready, which checks the beat count and the position of the last beat. The second mode delays address acceptance and applies periodic gaps and backpressure on both sides, which separates true handshake following from simple beat counting. Error responses are injected on the write response and on read beats at the start, middle and end of a burst, to show that the error flag is sticky and independent of where the bad beat falls. One write and one read are then overlapped to show that the two engines are independent.

// File: rtl/axi_burst_dma_pkg.sv
// Shared types and constants for the burst DMA master.
// Assumes a fixed 8-byte beat and a single transaction ID.
package axi_burst_dma_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ADDR,
        ENG_DATA,
        ENG_RESP
    } eng_state_t;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/dma_wr_engine.sv
// Write engine: accepts one command, issues one INCR burst and forwards
// stream words as write beats, then waits for the write response.
// Assumes an aligned start address and no 4 KB crossing (the caller's job).
module dma_wr_engine
    import axi_burst_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8,
    parameter int ID_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              err,
    output logic [ID_W-1:0]   awid,
    output logic [ADDR_W-1:0] awaddr,
    output logic [LEN_W-1:0]  awlen,
    output logic [2:0]        awsize,
    output logic [1:0]        awburst,
    output logic              awvalid,
    input  logic              awready,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic              wlast,
    output logic              wvalid,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready
);
    localparam int         STRB_W    = DATA_W / 8;
    localparam logic [2:0] SIZE_CODE = 3'($clog2(STRB_W));

    eng_state_t        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  beat_q;
    logic              err_q;
    logic              beat_go;

    assign beat_go = wvalid && wready;

    // Burst sequencing: command latch, address, data beats, response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            addr_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (cmd_valid) begin
                        addr_q <= cmd_addr;
                        len_q  <= cmd_len;
                        beat_q <= '0;
                        st_q   <= ENG_ADDR;
                    end
                end
                ENG_ADDR: begin
                    if (awready) st_q <= ENG_DATA;
                end
                ENG_DATA: begin
                    if (beat_go) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == len_q) st_q <= ENG_RESP;
                    end
                end
                ENG_RESP: begin
                    if (bvalid) begin
                        if (bresp != RESP_OKAY) err_q <= 1'b1;
                        st_q <= ENG_IDLE;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // Channel outputs decoded from the engine state.
    always_comb begin
        cmd_ready = (st_q == ENG_IDLE);
        awvalid   = (st_q == ENG_ADDR);
        awid      = '0;
        awaddr    = addr_q;
        awlen     = len_q;
        awsize    = SIZE_CODE;
        awburst   = BURST_INCR;
        wvalid    = (st_q == ENG_DATA) && in_valid;
        in_ready  = (st_q == ENG_DATA) && wready;
        wdata     = in_data;
        wstrb     = '1;
        wlast     = (st_q == ENG_DATA) && (beat_q == len_q);
        bready    = (st_q == ENG_RESP);
        err       = err_q;
    end

    // Ready must drop right after a command is taken.
    p_wcmd_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready && awvalid));
    // Address held until accepted.
    p_aw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));
    // Stream ready never runs ahead of the write channel.
    p_in_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> wready);
    // No beat after the final one.
    p_wlast_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_go && wlast) |=> !wvalid);
    // Completion only through the response handshake.
    p_wready_after_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> $past(bvalid && bready));
    // Error flag is sticky.
    p_werr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/dma_rd_engine.sv
// Read engine: accepts one command, issues one INCR read burst and
// forwards read beats to the output stream, stalling on backpressure.
// Assumes an aligned start address and no 4 KB crossing (the caller's job).
module dma_rd_engine
    import axi_burst_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8,
    parameter int ID_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              err,
    output logic [ID_W-1:0]   arid,
    output logic [ADDR_W-1:0] araddr,
    output logic [LEN_W-1:0]  arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    output logic              arvalid,
    input  logic              arready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast,
    input  logic              rvalid,
    output logic              rready
);
    localparam int         STRB_W    = DATA_W / 8;
    localparam logic [2:0] SIZE_CODE = 3'($clog2(STRB_W));

    eng_state_t        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              err_q;
    logic              beat_go;

    assign beat_go = rvalid && rready;

    // Burst sequencing: command latch, address, data until the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            addr_q <= '0;
            len_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (cmd_valid) begin
                        addr_q <= cmd_addr;
                        len_q  <= cmd_len;
                        st_q   <= ENG_ADDR;
                    end
                end
                ENG_ADDR: begin
                    if (arready) st_q <= ENG_DATA;
                end
                ENG_DATA: begin
                    if (beat_go) begin
                        if (rresp != RESP_OKAY) err_q <= 1'b1;
                        if (rlast) st_q <= ENG_IDLE;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // Channel outputs decoded from the engine state.
    always_comb begin
        cmd_ready = (st_q == ENG_IDLE);
        arvalid   = (st_q == ENG_ADDR);
        arid      = '0;
        araddr    = addr_q;
        arlen     = len_q;
        arsize    = SIZE_CODE;
        arburst   = BURST_INCR;
        rready    = (st_q == ENG_DATA) && out_ready;
        out_valid = (st_q == ENG_DATA) && rvalid;
        out_data  = rdata;
        err       = err_q;
    end

    // Ready must drop right after a command is taken.
    p_rcmd_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready && arvalid));
    // Address held until accepted.
    p_ar_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen)));
    // Read channel only drains when downstream takes the word.
    p_rready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rready |-> out_ready);
    // Completion only through the last read beat.
    p_rready_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> $past(rvalid && rready && rlast));
    // Error flag is sticky.
    p_rerr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/axi_burst_dma.sv
// Top of the burst DMA master: one write engine and one read engine
// sharing only clock and reset. Assumes commands respect 4 KB pages.
module axi_burst_dma #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8,
    parameter int ID_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   wr_cmd_addr,
    input  logic [LEN_W-1:0]    wr_cmd_len,
    input  logic                wr_cmd_valid,
    output logic                wr_cmd_ready,
    input  logic [DATA_W-1:0]   wr_in_data,
    input  logic                wr_in_valid,
    output logic                wr_in_ready,
    input  logic [ADDR_W-1:0]   rd_cmd_addr,
    input  logic [LEN_W-1:0]    rd_cmd_len,
    input  logic                rd_cmd_valid,
    output logic                rd_cmd_ready,
    output logic [DATA_W-1:0]   rd_out_data,
    output logic                rd_out_valid,
    input  logic                rd_out_ready,
    output logic                wr_err,
    output logic                rd_err,
    output logic [ID_W-1:0]     m_awid,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [LEN_W-1:0]    m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic [ID_W-1:0]     m_arid,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [LEN_W-1:0]    m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rlast,
    input  logic                m_rvalid,
    output logic                m_rready
);
    dma_wr_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ID_W(ID_W)
    ) wr_eng_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_addr(wr_cmd_addr), .cmd_len(wr_cmd_len),
        .cmd_valid(wr_cmd_valid), .cmd_ready(wr_cmd_ready),
        .in_data(wr_in_data), .in_valid(wr_in_valid), .in_ready(wr_in_ready),
        .err(wr_err),
        .awid(m_awid), .awaddr(m_awaddr), .awlen(m_awlen), .awsize(m_awsize),
        .awburst(m_awburst), .awvalid(m_awvalid), .awready(m_awready),
        .wdata(m_wdata), .wstrb(m_wstrb), .wlast(m_wlast),
        .wvalid(m_wvalid), .wready(m_wready),
        .bresp(m_bresp), .bvalid(m_bvalid), .bready(m_bready)
    );

    dma_rd_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ID_W(ID_W)
    ) rd_eng_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_addr(rd_cmd_addr), .cmd_len(rd_cmd_len),
        .cmd_valid(rd_cmd_valid), .cmd_ready(rd_cmd_ready),
        .out_data(rd_out_data), .out_valid(rd_out_valid), .out_ready(rd_out_ready),
        .err(rd_err),
        .arid(m_arid), .araddr(m_araddr), .arlen(m_arlen), .arsize(m_arsize),
        .arburst(m_arburst), .arvalid(m_arvalid), .arready(m_arready),
        .rdata(m_rdata), .rresp(m_rresp), .rlast(m_rlast),
        .rvalid(m_rvalid), .rready(m_rready)
    );

    // Engines come out of reset idle and ready (R1).
    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (wr_cmd_ready && rd_cmd_ready && !m_awvalid && !m_arvalid
                          && !wr_err && !rd_err));
endmodule

// File: tb/axi_burst_dma_tb_top.sv
// Bench: sweeps burst lengths and handshake patterns on both engines,
// injects error responses and overlaps a write with a read.
module axi_burst_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] wr_cmd_addr, rd_cmd_addr;
    logic [7:0]  wr_cmd_len, rd_cmd_len;
    logic        wr_cmd_valid, wr_cmd_ready, rd_cmd_valid, rd_cmd_ready;
    logic [63:0] wr_in_data, rd_out_data;
    logic        wr_in_valid, wr_in_ready, rd_out_valid, rd_out_ready;
    logic        wr_err, rd_err;
    logic [0:0]  m_awid, m_arid;
    logic [31:0] m_awaddr, m_araddr;
    logic [7:0]  m_awlen, m_arlen, m_wstrb;
    logic [2:0]  m_awsize, m_arsize;
    logic [1:0]  m_awburst, m_arburst, m_bresp, m_rresp;
    logic        m_awvalid, m_awready, m_arvalid, m_arready;
    logic [63:0] m_wdata, m_rdata;
    logic        m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
    logic        m_rlast, m_rvalid, m_rready;

    int total = 0;
    int bad   = 0;
    bit exp_wr_err = 1'b0;
    bit exp_rd_err = 1'b0;

    always #5 clk = ~clk;

    axi_burst_dma dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_cmd_addr(wr_cmd_addr), .wr_cmd_len(wr_cmd_len),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
        .wr_in_data(wr_in_data), .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
        .rd_cmd_addr(rd_cmd_addr), .rd_cmd_len(rd_cmd_len),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
        .rd_out_data(rd_out_data), .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready),
        .wr_err(wr_err), .rd_err(rd_err),
        .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
        .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input logic [31:0] a, input int k);
        return {a, 32'(k)} ^ 64'hC3A5_5A3C_0F0F_F0F0;
    endfunction

    task automatic idle_checks(input string req);
        chk(wr_cmd_ready == 1'b1, {req, " wr_cmd_ready"}, 64'(wr_cmd_ready), 64'd1);
        chk(rd_cmd_ready == 1'b1, {req, " rd_cmd_ready"}, 64'(rd_cmd_ready), 64'd1);
        chk(m_awvalid == 1'b0, {req, " awvalid"}, 64'(m_awvalid), 64'd0);
        chk(m_arvalid == 1'b0, {req, " arvalid"}, 64'(m_arvalid), 64'd0);
        chk(m_wvalid == 1'b0 && m_bready == 1'b0 && m_rready == 1'b0,
            {req, " wvalid/bready/rready"}, 64'({m_wvalid, m_bready, m_rready}), 64'd0);
        chk(wr_err == 1'b0 && rd_err == 1'b0, {req, " err flags"},
            64'({wr_err, rd_err}), 64'd0);
    endtask

    task automatic do_write(input logic [31:0] addr, input logic [7:0] len,
                            input bit stall, input logic [1:0] resp);
        int k = 0;
        int c = 0;
        @(negedge clk);
        wr_cmd_addr = addr; wr_cmd_len = len; wr_cmd_valid = 1'b1; m_awready = 1'b0;
        #1 chk(wr_cmd_ready == 1'b1, "R6 ready before cmd", 64'(wr_cmd_ready), 64'd1);
        @(negedge clk);
        wr_cmd_valid = 1'b0; m_awready = !stall; wr_in_valid = 1'b1; m_wready = 1'b1;
        #1;
        chk(wr_cmd_ready == 1'b0, "R2 ready drops", 64'(wr_cmd_ready), 64'd0);
        chk(m_awvalid == 1'b1, "R2 awvalid", 64'(m_awvalid), 64'd1);
        chk(m_awaddr == addr, "R2 awaddr", 64'(m_awaddr), 64'(addr));
        chk(m_awlen == len, "R2 awlen", 64'(m_awlen), 64'(len));
        chk(m_awsize == 3'd3 && m_awburst == 2'b01 && m_awid == 1'b0, "R2 size/burst/id",
            64'({m_awsize, m_awburst, m_awid}), 64'({3'd3, 2'b01, 1'b0}));
        chk(wr_in_ready == 1'b0 && m_wvalid == 1'b0, "R4 gated before addr",
            64'({wr_in_ready, m_wvalid}), 64'd0);
        if (stall) begin
            @(negedge clk);
            m_awready = 1'b1;
            #1 chk(m_awvalid == 1'b1 && m_awaddr == addr && m_awlen == len, "R3 aw held",
                   64'({m_awvalid, m_awaddr}), 64'({1'b1, addr}));
        end
        while (k <= int'(len)) begin
            bit iv;
            bit wr;
            @(negedge clk);
            m_awready = 1'b0;
            iv = stall ? ((c % 3) != 1) : 1'b1;
            wr = stall ? ((c % 4) != 2) : 1'b1;
            wr_in_valid = iv; m_wready = wr; wr_in_data = pat(addr, k);
            #1;
            chk(m_wvalid == iv, "R4 wvalid follows stream", 64'(m_wvalid), 64'(iv));
            chk(wr_in_ready == wr, "R4 in_ready follows wready", 64'(wr_in_ready), 64'(wr));
            chk(wr_cmd_ready == 1'b0, "R6 busy in data", 64'(wr_cmd_ready), 64'd0);
            if (iv && wr) begin
                chk(m_wdata == pat(addr, k), "R4 wdata", m_wdata, pat(addr, k));
                chk(m_wstrb == 8'hFF, "R4 wstrb", 64'(m_wstrb), 64'hFF);
                chk(m_wlast == (k == int'(len)), "R5 wlast position", 64'(m_wlast),
                    64'(k == int'(len)));
                k++;
            end
            c++;
        end
        @(negedge clk);
        wr_in_valid = 1'b1; m_wready = 1'b1; m_bvalid = 1'b0;
        #1;
        chk(m_wvalid == 1'b0, "R5 no extra beat", 64'(m_wvalid), 64'd0);
        chk(m_bready == 1'b1, "R6 bready after last", 64'(m_bready), 64'd1);
        chk(wr_cmd_ready == 1'b0, "R6 busy awaiting resp", 64'(wr_cmd_ready), 64'd0);
        @(negedge clk);
        wr_in_valid = 1'b0; m_wready = 1'b0; m_bvalid = 1'b1; m_bresp = resp;
        #1 chk(wr_cmd_ready == 1'b0, "R6 busy during resp", 64'(wr_cmd_ready), 64'd0);
        @(negedge clk);
        m_bvalid = 1'b0; m_bresp = 2'b00;
        if (resp != 2'b00) exp_wr_err = 1'b1;
        #1;
        chk(wr_cmd_ready == 1'b1, "R6 ready after resp", 64'(wr_cmd_ready), 64'd1);
        chk(m_bready == 1'b0, "R6 bready drops", 64'(m_bready), 64'd0);
        chk(wr_err == exp_wr_err, "R10 wr_err", 64'(wr_err), 64'(exp_wr_err));
    endtask

    task automatic do_read(input logic [31:0] addr, input logic [7:0] len,
                           input bit bp, input int bad_beat);
        int k = 0;
        int c = 0;
        @(negedge clk);
        rd_cmd_addr = addr; rd_cmd_len = len; rd_cmd_valid = 1'b1; m_arready = 1'b0;
        #1 chk(rd_cmd_ready == 1'b1, "R9 ready before cmd", 64'(rd_cmd_ready), 64'd1);
        @(negedge clk);
        rd_cmd_valid = 1'b0; m_arready = !bp; m_rvalid = 1'b1; rd_out_ready = 1'b1;
        m_rdata = 64'hDEAD;
        #1;
        chk(rd_cmd_ready == 1'b0, "R9 ready drops", 64'(rd_cmd_ready), 64'd0);
        chk(m_arvalid == 1'b1 && m_araddr == addr, "R7 arvalid/araddr",
            64'({m_arvalid, m_araddr}), 64'({1'b1, addr}));
        chk(m_arlen == len, "R7 arlen", 64'(m_arlen), 64'(len));
        chk(m_arsize == 3'd3 && m_arburst == 2'b01 && m_arid == 1'b0, "R7 size/burst/id",
            64'({m_arsize, m_arburst, m_arid}), 64'({3'd3, 2'b01, 1'b0}));
        chk(rd_out_valid == 1'b0 && m_rready == 1'b0, "R8 gated before addr",
            64'({rd_out_valid, m_rready}), 64'd0);
        if (bp) begin
            @(negedge clk);
            m_arready = 1'b1;
            #1 chk(m_arvalid == 1'b1 && m_araddr == addr && m_arlen == len, "R7 ar held",
                   64'({m_arvalid, m_araddr}), 64'({1'b1, addr}));
        end
        while (k <= int'(len)) begin
            bit rv;
            bit orr;
            @(negedge clk);
            m_arready = 1'b0;
            rv  = bp ? ((c % 3) != 0) : 1'b1;
            orr = bp ? ((c % 4) != 1) : 1'b1;
            m_rvalid = rv; m_rdata = pat(addr, k); m_rlast = (k == int'(len));
            m_rresp = (k == bad_beat) ? 2'b10 : 2'b00; rd_out_ready = orr;
            #1;
            chk(rd_out_valid == rv, "R8 out_valid follows rvalid", 64'(rd_out_valid), 64'(rv));
            chk(m_rready == orr, "R8 rready follows out_ready", 64'(m_rready), 64'(orr));
            chk(rd_cmd_ready == 1'b0, "R9 busy in data", 64'(rd_cmd_ready), 64'd0);
            if (rv && orr) begin
                chk(rd_out_data == pat(addr, k), "R8 out_data", rd_out_data, pat(addr, k));
                k++;
            end
            c++;
        end
        @(negedge clk);
        m_rvalid = 1'b0; m_rlast = 1'b0; m_rresp = 2'b00; rd_out_ready = 1'b1;
        if (bad_beat >= 0 && bad_beat <= int'(len)) exp_rd_err = 1'b1;
        #1;
        chk(rd_cmd_ready == 1'b1, "R9 ready after last", 64'(rd_cmd_ready), 64'd1);
        chk(m_rready == 1'b0, "R9 rready drops", 64'(m_rready), 64'd0);
        chk(rd_err == exp_rd_err, "R10 rd_err", 64'(rd_err), 64'(exp_rd_err));
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        wr_cmd_addr = '0; wr_cmd_len = '0; wr_cmd_valid = 1'b0;
        rd_cmd_addr = '0; rd_cmd_len = '0; rd_cmd_valid = 1'b0;
        wr_in_data = '0; wr_in_valid = 1'b0; rd_out_ready = 1'b0;
        m_awready = 1'b0; m_wready = 1'b0; m_bresp = 2'b00; m_bvalid = 1'b0;
        m_arready = 1'b0; m_rdata = '0; m_rresp = 2'b00; m_rlast = 1'b0; m_rvalid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 idle_checks("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1 idle_checks("R1 after reset");

        // Length and pattern sweep, write engine.
        for (int len = 0; len < 16; len++)
            for (int s = 0; s < 2; s++)
                do_write(32'h0001_0000 + 32'(len * 256), 8'(len), s[0], 2'b00);
        do_write(32'h0002_0000, 8'd255, 1'b0, 2'b00);
        do_write(32'h0003_0000, 8'd255, 1'b1, 2'b00);

        // Length and pattern sweep, read engine.
        for (int len = 0; len < 16; len++)
            for (int s = 0; s < 2; s++)
                do_read(32'h0004_0000 + 32'(len * 256), 8'(len), s[0], -1);
        do_read(32'h0005_0000, 8'd255, 1'b0, -1);
        do_read(32'h0005_1000, 8'd255, 1'b1, -1);

        // R11: both engines at once.
        fork
            do_write(32'h0006_0000, 8'd20, 1'b1, 2'b00);
            do_read(32'h0007_0000, 8'd20, 1'b1, -1);
        join
        chk(wr_cmd_ready && rd_cmd_ready, "R11 both idle after overlap",
            64'({wr_cmd_ready, rd_cmd_ready}), 64'd3);

        // R10: error responses, then good bursts keep the flags set.
        do_write(32'h0008_0000, 8'd3, 1'b0, 2'b10);
        do_write(32'h0008_1000, 8'd3, 1'b1, 2'b00);
        do_read(32'h0009_0000, 8'd5, 1'b0, 2);
        do_read(32'h0009_1000, 8'd5, 1'b1, -1);

        // Reset clears the sticky flags; then error on first and last read beat.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_wr_err = 1'b0;
        exp_rd_err = 1'b0;
        #1 idle_checks("R10 reset clears errors R1");
        do_read(32'h000A_0000, 8'd4, 1'b0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_rd_err = 1'b0;
        do_read(32'h000B_0000, 8'd4, 1'b1, 4);
        do_write(32'h000C_0000, 8'd0, 1'b1, 2'b11);

        finish_run();
    end
endmodule